// File: doc/BRIEF.md
# Row-Addressed Fuse Line Programming Sequencer

This block drives the serial programming pins of a small programmable-logic device whose fuse array is addressed one row at a time. The row is selected through six parallel address pins. The line's bits then travel over a serial clock, a serial data input and a serial data output. An active-low strobe latches a line for readout or fires the programming pulse. A program/verify select picks the direction. A host hands the sequencer a command made of a row number, a line length in bits, a read or write flag, a programming pulse time in milliseconds and, for writes, a data word. The sequencer then runs the whole pin sequence by itself.

The two directions order their steps differently. A read latches the addressed line with a short strobe pulse first. It then samples the data output once per bit, with a short clock pulse between samples, and collects the bits into a word from bit 0 upward. A write presents bit 0 first and clocks the whole line into the device. Only then does it hold the strobe low for the long programming pulse. The short pulse widths come from a microsecond tick derived from the system clock. The long programming pulse counts whole milliseconds. Typical line lengths are 64 bits for fuse rows, 82 for the configuration row, and a single set bit for the erase and security rows. A line can be up to 128 bits long.

Top module: `fuse_row_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `prg_strobe_n` is 1 and `prg_sclk`, `prg_sdi`, `prg_pv` and `prg_row` are all 0.
- R2: A read (`cmd_write`=0) drives `prg_pv` to 0 and `prg_row` to the commanded row for the whole operation, and keeps `prg_sdi` at 0. It gives exactly one strobe low pulse before any clock pulse, followed by L-1 clock high pulses for a line length L of 1 or more. `rd_line` bit k holds the level of `prg_sdo` seen after the strobe (k=0) or after the k-th clock pulse. All bits at and above L are 0.
- R3: A write (`cmd_write`=1) drives `prg_pv` to 1 and `prg_row` to the row for the whole operation. It gives exactly L clock high pulses, and `prg_sdi` is stable while `prg_sclk` is high. At the k-th rising clock edge (k counted from 0), `prg_sdi` equals `cmd_wdata` bit k, so bit 0 goes out first.
- R4: After the last clocked bit of a write, `prg_strobe_n` stays low for exactly `cmd_pulse_ms` × US_PER_MS × (CLK_HZ/1e6) clock cycles, with a value of 0 treated as 1 ms. This is the write's only strobe pulse, and `prg_pv` is back at 0 when `done` pulses.
- R5: Every clock high pulse, and the read strobe low pulse, lasts exactly PULSE_US × (CLK_HZ/1e6) clock cycles.
- R6: A line length above MAX_BITS is treated as MAX_BITS. A length of 0 gives no clock pulses: a write goes straight to the programming pulse, and a read gives only its strobe pulse and returns `rd_line`=0.
- R7: A command is taken only while `busy` is 0. A `cmd_valid` raised while busy starts no operation and changes neither the row nor the sequence in progress.
- R8: `busy` rises the cycle after a command is taken. `done` is high for exactly one cycle, namely the first cycle in which `busy` is low again.
- R9: `prg_sclk` is never high while `prg_strobe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_write | input | 1 | 1 = program the line, 0 = read it |
| cmd_row | input | ROW_W | Row number to place on the address pins |
| cmd_len | input | LEN_W | Line length in bits |
| cmd_pulse_ms | input | MS_W | Programming pulse time in ms (0 means 1) |
| cmd_wdata | input | MAX_BITS | Write data, bit 0 sent first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on return to idle |
| rd_line | output | MAX_BITS | Read data, first bit read in bit 0 |
| prg_row | output | ROW_W | Row address pins |
| prg_sclk | output | 1 | Serial clock pin |
| prg_sdi | output | 1 | Serial data into the device |
| prg_strobe_n | output | 1 | Active-low strobe pin |
| prg_pv | output | 1 | Program/verify select, 1 = program |
| prg_sdo | input | 1 | Serial data out of the device |

## Verification
The assertions check the pin rules that must hold on every cycle: the idle pin levels, clock and strobe never overlapping, row and direction select held steady for an operation, data steady while the clock is high, and the single-cycle `done` at the busy fall. What they cannot show is checked only by the bench's scenarios, which run against a model device on the pins: the bit order on the wire, the data that returns on a read, the exact pulse widths in cycles, the clamping and zero-length cases, and commands being ignored while busy.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_STRB_REC,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_PROG,
    ST_PROG_REC
  } seq_state_t;

  function automatic int cyc_per_us(input int clk_hz);
    return clk_hz / 1_000_000;
  endfunction

endpackage

// File: rtl/fuse_step_timer.sv
module fuse_step_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int UNIT_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [UNIT_W-1:0] units,
  output logic              expire
);
  import fuse_seq_pkg::*;

  localparam int CYC_US = cyc_per_us(CLK_HZ);
  localparam int PRE_W  = (CYC_US > 1) ? $clog2(CYC_US) : 1;

  logic              active;
  logic [UNIT_W-1:0] left;
  logic              pre_zero;

  generate
    if (CYC_US > 1) begin : g_prescale
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre <= '0;
        end else if (load || (active && pre == '0)) begin
          pre <= PRE_W'(CYC_US - 1);
        end else if (active) begin
          pre <= pre - 1'b1;
        end
      end
      assign pre_zero = (pre == '0);
    end else begin : g_direct
      assign pre_zero = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left   <= '0;
    end else if (load) begin
      active <= 1'b1;
      left   <= units;
    end else if (active && pre_zero) begin
      left <= left - 1'b1;
      if (left == UNIT_W'(1)) active <= 1'b0;
    end
  end

  assign expire = active && pre_zero && (left == UNIT_W'(1));

  AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |-> (units != '0)); // R4
  AST_TMR_LEFT_LIVE: assert property (@(posedge clk) disable iff (rst)
    active |-> (left != '0)); // R5

endmodule

// File: rtl/fuse_line_reg.sv
module fuse_line_reg #(
  parameter int MAX_BITS = 128,
  parameter int IDX_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic                cap_en,
  input  logic [IDX_W-1:0]    cap_idx,
  input  logic                cap_bit,
  input  logic [IDX_W-1:0]    sel_idx,
  output logic                sel_bit,
  output logic [MAX_BITS-1:0] line
);

  generate
    for (genvar i = 0; i < MAX_BITS; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          line[i] <= 1'b0;
        end else if (load) begin
          line[i] <= load_data[i];
        end else if (cap_en && (cap_idx == IDX_W'(i))) begin
          line[i] <= cap_bit;
        end
      end
    end
  endgenerate

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (sel_idx == IDX_W'(i)) sel_bit = line[i];
    end
  end

  AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (int'(cap_idx) < MAX_BITS)); // R6
  AST_LOAD_NO_CAP: assert property (@(posedge clk) disable iff (rst)
    load |-> !cap_en); // R7

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl #(
  parameter int MAX_BITS  = 128,
  parameter int ROW_W     = 6,
  parameter int LEN_W     = 8,
  parameter int MS_W      = 8,
  parameter int PULSE_US  = 2,
  parameter int US_PER_MS = 1000,
  parameter int UNIT_W    = 18,
  parameter int IDX_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [MS_W-1:0]   cmd_pulse_ms,
  input  logic              cmd_first_bit,
  input  logic              tmr_expire,
  output logic              tmr_load,
  output logic [UNIT_W-1:0] tmr_units,
  output logic              line_load,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [IDX_W-1:0]  sel_idx,
  input  logic              sel_bit,
  output logic              busy,
  output logic              done,
  output logic [ROW_W-1:0]  prg_row,
  output logic              prg_sclk,
  output logic              prg_sdi,
  output logic              prg_strobe_n,
  output logic              prg_pv
);
  import fuse_seq_pkg::*;

  seq_state_t       state, nxt;
  logic [IDX_W-1:0] idx, len_q, len_in, len_eff;
  logic             wr_q, wr_eff;
  logic [ROW_W-1:0] row_q, row_eff;
  logic [MS_W-1:0]  ms_q;
  logic             accept;
  logic [UNIT_W-1:0] prog_units;

  assign accept  = (state == ST_IDLE) && cmd_valid;
  assign len_in  = (int'(cmd_len) > MAX_BITS) ? IDX_W'(MAX_BITS) : IDX_W'(cmd_len);
  assign wr_eff  = accept ? cmd_write : wr_q;
  assign row_eff = accept ? cmd_row : row_q;
  assign len_eff = accept ? len_in : len_q;

  assign prog_units = ((ms_q == '0) ? UNIT_W'(1) : UNIT_W'(ms_q)) * UNIT_W'(US_PER_MS);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (cmd_valid) nxt = ST_SETUP;
      ST_SETUP:    if (tmr_expire)
                     nxt = !wr_q ? ST_STRB : ((len_q == '0) ? ST_PROG : ST_CLK_HI);
      ST_STRB:     if (tmr_expire) nxt = ST_STRB_REC;
      ST_STRB_REC: if (tmr_expire)
                     nxt = (len_q <= IDX_W'(1)) ? ST_IDLE : ST_CLK_HI;
      ST_CLK_HI:   if (tmr_expire) nxt = ST_CLK_LO;
      ST_CLK_LO:   if (tmr_expire) begin
                     if (wr_q) nxt = (idx == len_q) ? ST_PROG : ST_CLK_HI;
                     else      nxt = (idx + 1'b1 == len_q) ? ST_IDLE : ST_CLK_HI;
                   end
      ST_PROG:     if (tmr_expire) nxt = ST_PROG_REC;
      ST_PROG_REC: if (tmr_expire) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign tmr_load  = (nxt != state) && (nxt != ST_IDLE);
  assign tmr_units = (nxt == ST_PROG) ? prog_units : UNIT_W'(PULSE_US);
  assign line_load = accept;
  assign cap_en    = !wr_q && tmr_expire &&
                     (((state == ST_STRB_REC) && (len_q != '0)) || (state == ST_CLK_LO));
  assign cap_idx   = idx;
  assign sel_idx   = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      idx          <= '0;
      wr_q         <= 1'b0;
      row_q        <= '0;
      len_q        <= '0;
      ms_q         <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      prg_row      <= '0;
      prg_sclk     <= 1'b0;
      prg_sdi      <= 1'b0;
      prg_strobe_n <= 1'b1;
      prg_pv       <= 1'b0;
    end else begin
      state <= nxt;
      busy  <= (nxt != ST_IDLE);
      done  <= (state != ST_IDLE) && (nxt == ST_IDLE);

      if (accept) begin
        wr_q  <= cmd_write;
        row_q <= cmd_row;
        len_q <= len_in;
        ms_q  <= cmd_pulse_ms;
        idx   <= '0;
      end else if (tmr_expire) begin
        if (wr_q && state == ST_CLK_HI) idx <= idx + 1'b1;
        if (!wr_q && state == ST_STRB_REC) idx <= IDX_W'(1);
        if (!wr_q && state == ST_CLK_LO) idx <= idx + 1'b1;
      end

      prg_sclk     <= (nxt == ST_CLK_HI);
      prg_strobe_n <= !((nxt == ST_STRB) || (nxt == ST_PROG));
      prg_pv       <= (nxt != ST_IDLE) && wr_eff;
      prg_row      <= (nxt == ST_IDLE) ? '0 : row_eff;

      if (nxt == ST_IDLE || nxt == ST_PROG || !wr_eff) begin
        prg_sdi <= 1'b0;
      end else if (accept) begin
        prg_sdi <= (len_eff != '0) && cmd_first_bit;
      end else if (state == ST_CLK_HI && nxt == ST_CLK_LO) begin
        prg_sdi <= (idx + 1'b1 < len_q) ? sel_bit : 1'b0;
      end
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (prg_strobe_n && !prg_sclk && !prg_sdi && !prg_pv && prg_row == '0)); // R1
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(prg_row)); // R2
  AST_PV_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(prg_pv)); // R3
  AST_SDI_STEADY: assert property (@(posedge clk) disable iff (rst)
    prg_sclk |-> $stable(prg_sdi)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R8
  AST_NO_CLK_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(prg_sclk && !prg_strobe_n)); // R9

endmodule

// File: rtl/fuse_row_seq.sv
module fuse_row_seq #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PULSE_US  = 2,
  parameter int US_PER_MS = 1000,
  parameter int MAX_BITS  = 128,
  parameter int ROW_W     = 6,
  parameter int LEN_W     = 8,
  parameter int MS_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic [ROW_W-1:0]    cmd_row,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [MS_W-1:0]     cmd_pulse_ms,
  input  logic [MAX_BITS-1:0] cmd_wdata,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rd_line,
  output logic [ROW_W-1:0]    prg_row,
  output logic                prg_sclk,
  output logic                prg_sdi,
  output logic                prg_strobe_n,
  output logic                prg_pv,
  input  logic                prg_sdo
);

  localparam int IDX_W    = $clog2(MAX_BITS + 1);
  localparam int MAX_UNIT = ((2 ** MS_W) - 1) * US_PER_MS + PULSE_US;
  localparam int UNIT_W   = $clog2(MAX_UNIT + 1);

  logic              tmr_load, tmr_expire;
  logic [UNIT_W-1:0] tmr_units;
  logic              line_load, cap_en, sel_bit;
  logic [IDX_W-1:0]  cap_idx, sel_idx;

  fuse_step_timer #(.CLK_HZ(CLK_HZ), .UNIT_W(UNIT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .units(tmr_units), .expire(tmr_expire)
  );

  fuse_line_reg #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_line (
    .clk(clk), .rst(rst), .load(line_load),
    .load_data(cmd_write ? cmd_wdata : '0),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_bit(prg_sdo),
    .sel_idx(sel_idx), .sel_bit(sel_bit), .line(rd_line)
  );

  fuse_seq_ctrl #(
    .MAX_BITS(MAX_BITS), .ROW_W(ROW_W), .LEN_W(LEN_W), .MS_W(MS_W),
    .PULSE_US(PULSE_US), .US_PER_MS(US_PER_MS), .UNIT_W(UNIT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_row(cmd_row),
    .cmd_len(cmd_len), .cmd_pulse_ms(cmd_pulse_ms), .cmd_first_bit(cmd_wdata[0]),
    .tmr_expire(tmr_expire), .tmr_load(tmr_load), .tmr_units(tmr_units),
    .line_load(line_load), .cap_en(cap_en), .cap_idx(cap_idx),
    .sel_idx(sel_idx), .sel_bit(sel_bit),
    .busy(busy), .done(done),
    .prg_row(prg_row), .prg_sclk(prg_sclk), .prg_sdi(prg_sdi),
    .prg_strobe_n(prg_strobe_n), .prg_pv(prg_pv)
  );

endmodule

// File: tb/tb_fuse_row_seq.sv
module tb_fuse_row_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int CYC_US     = CLK_HZ / 1_000_000;
  localparam int PULSE_US   = 1;
  localparam int US_PER_MS  = 20;
  localparam int STEP_CYC   = PULSE_US * CYC_US;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [5:0] cmd_row = '0;
  logic [7:0] cmd_len = '0, cmd_pulse_ms = '0;
  logic [127:0] cmd_wdata = '0;
  logic busy, done, prg_sclk, prg_sdi, prg_strobe_n, prg_pv, prg_sdo;
  logic [127:0] rd_line;
  logic [5:0] prg_row;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fuse_row_seq #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .US_PER_MS(US_PER_MS)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_row(cmd_row), .cmd_len(cmd_len), .cmd_pulse_ms(cmd_pulse_ms),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_line(rd_line),
    .prg_row(prg_row), .prg_sclk(prg_sclk), .prg_sdi(prg_sdi),
    .prg_strobe_n(prg_strobe_n), .prg_pv(prg_pv), .prg_sdo(prg_sdo)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mask(input int len);
    return (len >= 128) ? {128{1'b1}} : ((128'd1 << len) - 128'd1);
  endfunction

  // model device and pin monitor
  logic [127:0] mem [64];
  logic [127:0] exp_mem [64];
  logic [127:0] cap, rd_shadow;
  int wcnt, rd_pos, sclk_pulses, strobe_falls, hi_run, lo_run, last_lo;
  int bad_width, overlap, clk_before_strb, sdi_in_read, prog_row;
  logic prv_sclk = 1'b0, prv_strb = 1'b1;

  always_comb prg_sdo = (rd_pos < 128) ? rd_shadow[rd_pos[6:0]] : 1'b0;

  task automatic clear_monitor();
    cap = '0; wcnt = 0; sclk_pulses = 0; strobe_falls = 0; hi_run = 0; lo_run = 0;
    last_lo = 0; bad_width = 0; overlap = 0; clk_before_strb = 0; sdi_in_read = 0;
    prog_row = -1;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (prg_sclk) hi_run++;
      if (!prg_strobe_n) lo_run++;
      if (!prv_sclk && prg_sclk) begin
        if (prg_pv && wcnt < 128) cap[wcnt] = prg_sdi;
        if (prg_pv) wcnt++;
        if (!prg_pv && strobe_falls == 0) clk_before_strb++;
      end
      if (prv_sclk && !prg_sclk) begin
        sclk_pulses++;
        if (hi_run != STEP_CYC) bad_width++;
        hi_run = 0;
        if (!prg_pv) rd_pos++;
      end
      if (prv_strb && !prg_strobe_n) begin
        strobe_falls++;
        if (!prg_pv) begin rd_shadow = mem[prg_row]; rd_pos = 0; end
      end
      if (!prv_strb && prg_strobe_n) begin
        last_lo = lo_run; lo_run = 0;
        if (prg_pv) begin
          prog_row = int'(prg_row);
          mem[prg_row] = cap & mask(wcnt);
        end else if (last_lo != STEP_CYC) bad_width++;
      end
      if (prg_sclk && !prg_strobe_n) overlap++;
      if (busy && !prg_pv && prg_sdi) sdi_in_read++;
      prv_sclk = prg_sclk;
      prv_strb = prg_strobe_n;
    end
  end

  bit done_ok;

  task automatic run_cmd(input bit wr, input int row, input int len, input int ms,
                         input logic [127:0] data, input bit poke);
    int t;
    @(negedge clk);
    cmd_write = wr; cmd_row = 6'(row); cmd_len = 8'(len);
    cmd_pulse_ms = 8'(ms); cmd_wdata = data; cmd_valid = 1'b1;
    @(posedge clk);
    #1 clear_monitor();
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1, "R8", "busy after accept", 128'(busy), 128'd1);
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_row = 6'd9; cmd_write = 1'b0; cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    t = 0;
    while (done !== 1'b1 && t < 50000) begin @(negedge clk); t++; end
    check(t < 50000, "R8", "done seen", 128'(t), 128'd0);
    done_ok = (busy === 1'b0) && (prg_pv === 1'b0);
    @(negedge clk);
    done_ok = done_ok && (done === 1'b0);
  endtask

  // stimulus table: write flag, row, length, pulse ms, data
  localparam int NV = 7;
  localparam bit          V_WR  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int          V_ROW [NV] = '{5, 60, 63, 5, 60, 20, 61};
  localparam int          V_LEN [NV] = '{64, 82, 1, 64, 82, 100, 1};
  localparam int          V_MS  [NV] = '{2, 1, 3, 0, 0, 0, 0};
  localparam logic [127:0] V_DAT [NV] = '{
    128'h0000_0000_0000_0000_A5C3_0F1E_8899_7766,
    128'h0000_0000_0003_5A5A_DEAD_BEEF_0123_4567,
    128'h1, 128'h0, 128'h0, 128'h0, 128'h1};

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int eff;
    logic [127:0] exp;
    for (int r = 0; r < 64; r++) begin
      mem[r] = {4{32'hC0DE_0000 | 32'(r * 37)}};
      exp_mem[r] = mem[r];
    end
    rd_shadow = '0; rd_pos = 0;
    clear_monitor();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(prg_strobe_n === 1'b1 && prg_sclk === 1'b0 && prg_sdi === 1'b0 &&
          prg_pv === 1'b0 && prg_row === 6'd0 && busy === 1'b0, "R1", "idle pins",
          {prg_strobe_n, prg_sclk, prg_sdi, prg_pv, prg_row, busy},
          {1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0});

    for (int v = 0; v < NV; v++) begin
      run_cmd(V_WR[v], V_ROW[v], V_LEN[v], V_MS[v], V_DAT[v], 1'b0);
      check(done_ok, "R8", "done single cycle, idle after", 128'(done_ok), 128'd1);
      check(bad_width == 0, "R5", "pulse widths", 128'(bad_width), 128'd0);
      check(overlap == 0, "R9", "clock within strobe", 128'(overlap), 128'd0);
      if (V_WR[v]) begin
        exp = V_DAT[v] & mask(V_LEN[v]);
        exp_mem[V_ROW[v]] = exp;
        check(wcnt == V_LEN[v], "R3", "bits clocked", 128'(wcnt), 128'(V_LEN[v]));
        check((cap & mask(V_LEN[v])) == exp, "R3", "bits on sdi", cap, exp);
        check(prog_row == V_ROW[v], "R3", "row at program", 128'(prog_row), 128'(V_ROW[v]));
        eff = (V_MS[v] == 0) ? 1 : V_MS[v];
        check(last_lo == eff * US_PER_MS * CYC_US, "R4", "program pulse",
              128'(last_lo), 128'(eff * US_PER_MS * CYC_US));
        check(strobe_falls == 1, "R4", "strobe count", 128'(strobe_falls), 128'd1);
      end else begin
        exp = exp_mem[V_ROW[v]] & mask(V_LEN[v]);
        check(rd_line == exp, "R2", "read data", rd_line, exp);
        check(sclk_pulses == V_LEN[v] - 1, "R2", "read clocks",
              128'(sclk_pulses), 128'(V_LEN[v] - 1));
        check(strobe_falls == 1 && clk_before_strb == 0, "R2", "strobe first",
              128'(clk_before_strb), 128'd0);
        check(sdi_in_read == 0, "R2", "sdi low in read", 128'(sdi_in_read), 128'd0);
      end
    end

    // R6 length clamp on write and read
    run_cmd(1'b1, 10, 200, 1, {128{1'b1}}, 1'b0);
    check(wcnt == 128, "R6", "clamped write bits", 128'(wcnt), 128'd128);
    run_cmd(1'b0, 10, 200, 0, '0, 1'b0);
    check(rd_line == {128{1'b1}}, "R6", "clamped read data", rd_line, {128{1'b1}});
    check(sclk_pulses == 127, "R6", "clamped read clocks", 128'(sclk_pulses), 128'd127);

    // R6 zero-length write (also R4 pulse value 0 -> 1 ms)
    run_cmd(1'b1, 63, 0, 0, 128'h1, 1'b0);
    check(sclk_pulses == 0, "R6", "zero write clocks", 128'(sclk_pulses), 128'd0);
    check(last_lo == US_PER_MS * CYC_US, "R4", "zero ms pulse",
          128'(last_lo), 128'(US_PER_MS * CYC_US));

    // R6 zero-length read
    run_cmd(1'b0, 5, 0, 0, '0, 1'b0);
    check(strobe_falls == 1 && sclk_pulses == 0, "R6", "zero read pins",
          128'(sclk_pulses), 128'd0);
    check(rd_line == '0, "R6", "zero read data", rd_line, 128'd0);

    // R7 command raised while busy is ignored
    run_cmd(1'b1, 7, 8, 1, 128'h5A, 1'b1);
    check(prog_row == 7 && wcnt == 8, "R7", "op unchanged by busy command",
          128'(prog_row), 128'd7);
    repeat (30) @(negedge clk);
    check(busy === 1'b0 && strobe_falls == 1, "R7", "no second op",
          128'(strobe_falls), 128'd1);
    check(prg_strobe_n === 1'b1 && prg_pv === 1'b0 && prg_row === 6'd0, "R1",
          "idle pins after ops", {prg_strobe_n, prg_pv, prg_row}, {1'b1, 1'b0, 6'd0});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule